// File: doc/BRIEF.md
# Oversampling Serial Bit Decoder

This block turns a serial input line into decided bit values. A sampling tick that runs at sixteen times the bit rate tells it when to take each sample. While idle it waits for a low sample, which it treats as the first sample of a start cell. After that it gathers sixteen samples for every cell of the frame and decides each cell with one of two rules. The lenient rule accepts a plain majority. The strict rule requires the winning level to reach a programmable count and flags the cell when it does not.

For every cell the block presents the decided value, an error flag, the cell's position in the frame and the raw sixteen-sample vector. From the vector, software or a test harness can tell a shifted sampling window (samples split into two clean runs) from a noisy channel (scattered minority samples). When the stop cell completes, the block also reports the assembled data byte, a parity mismatch, a framing error and a combined sampling-error flag.

Top module: `ovs_bit_decoder`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is 0.
- R2: In idle, a tick with `rxd` high changes nothing. A tick with `rxd` low starts a frame, and that sample is the first sample of cell 0.
- R3: Each cell takes sixteen consecutive ticks. In the clock after the edge that takes the sixteenth sample, `bit_valid` is high for exactly one cycle. `bit_samples` then holds the cell's samples with the earliest in bit 15 and the latest in bit 0. `bit_pos` holds the cell index: 0 start, 1 to 8 data, 9 parity, 10 stop.
- R4: In lenient mode (`strict_mode`=0), `bit_value` is 1 when at least 8 samples are high and 0 otherwise. `bit_error` is 1 only for an 8/8 tie, which decides as 1.
- R5: In strict mode, a cell with at least T high samples decides 1 without error, and a cell with at least T low samples decides 0 without error. Any other cell decides by majority (tie gives 1) with `bit_error`=1.
- R6: T is `threshold` clamped into the range 9 to 16. A value below 9 acts as 9, and a value above 16 acts as 16.
- R7: In lenient mode, a cell in which fewer than 8 samples differ from the sent level decodes to that level without error.
- R8: A start cell that decides as 1 is still reported on the bit outputs. The frame is then dropped without `frame_valid`, and the block returns to idle.
- R9: Data cells are assembled least significant bit first into `frame_data`. `frame_valid` pulses together with the stop cell's `bit_valid`.
- R10: `parity_err` is 1 when the number of ones across the eight data bits and the parity cell is odd while `odd_parity`=0, or even while `odd_parity`=1.
- R11: `framing_err` is 1 when the stop cell decides as 0.
- R12: `sample_err` is the OR of `bit_error` over all eleven cells of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Sampling strobe, sixteen per bit cell |
| rxd | input | 1 | Serial line |
| strict_mode | input | 1 | 0 lenient majority, 1 strict threshold |
| threshold | input | 5 | Strict-mode required count (clamped 9..16) |
| odd_parity | input | 1 | 0 even parity, 1 odd parity |
| bit_valid | output | 1 | One-cycle strobe per decided cell |
| bit_value | output | 1 | Decided level |
| bit_error | output | 1 | Sampling error of the cell |
| bit_samples | output | 16 | Raw samples, earliest in bit 15 |
| bit_pos | output | 4 | Cell index within the frame |
| frame_valid | output | 1 | One-cycle strobe at frame end |
| frame_data | output | 8 | Assembled data byte |
| parity_err | output | 1 | Parity mismatch |
| framing_err | output | 1 | Stop cell decided low |
| sample_err | output | 1 | Any cell of the frame had a sampling error |

## Verification
Every cell result and every frame result is registered once, on the edge that takes the cell's sixteenth tick. The bench therefore reads them at the falling edge straight after that tick, inside the same task that drove the samples. It is the only point in the cycle where `bit_valid` and `frame_valid` are high. Idle behaviour and dropped frames are judged from strobe counters that are sampled on rising edges and read several cycles later.

// File: rtl/ovs_pkg.sv
package ovs_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rx_state_e;
endpackage

// File: rtl/ovs_vote.sv
module ovs_vote #(
  parameter int N_SAMP = 16,
  parameter int THR_W  = 5
) (
  input  logic [N_SAMP-1:0] samples,
  input  logic              strict_mode,
  input  logic [THR_W-1:0]  threshold,
  output logic              value,
  output logic              error
);
  localparam int CNT_W = $clog2(N_SAMP + 1);
  localparam int HALF  = N_SAMP / 2;

  logic [CNT_W-1:0] ones, zeros, thr_eff;

  always_comb begin
    ones = '0;
    for (int i = 0; i < N_SAMP; i++) ones = ones + CNT_W'(samples[i]);
  end

  assign zeros = CNT_W'(N_SAMP) - ones;

  // clamp the programmed count into (majority, all samples]
  always_comb begin
    if (threshold < THR_W'(HALF + 1))     thr_eff = CNT_W'(HALF + 1);
    else if (threshold > THR_W'(N_SAMP))  thr_eff = CNT_W'(N_SAMP);
    else                                  thr_eff = CNT_W'(threshold);
  end

  assign value = (ones >= CNT_W'(HALF));
  assign error = strict_mode ? !((ones >= thr_eff) || (zeros >= thr_eff))
                             : (ones == CNT_W'(HALF));
endmodule

// File: rtl/ovs_cell_timer.sv
module ovs_cell_timer #(
  parameter int N_SAMP = 16,
  parameter int CELLS  = 11
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       tick,
  input  logic                       rxd,
  input  logic                       abort,
  output logic                       cell_done,
  output logic [$clog2(CELLS)-1:0]   cell_idx,
  output logic [N_SAMP-1:0]          samp_next
);
  import ovs_pkg::*;
  localparam int SC_W = $clog2(N_SAMP);
  localparam int CI_W = $clog2(CELLS);

  rx_state_e          state;
  logic [SC_W-1:0]    scnt;
  logic [N_SAMP-1:0]  shreg;

  assign samp_next = {shreg[N_SAMP-2:0], rxd};
  assign cell_done = tick && (state == ST_RUN) && (scnt == SC_W'(N_SAMP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      scnt     <= '0;
      cell_idx <= '0;
      shreg    <= '1;
    end else if (tick) begin
      shreg <= samp_next;
      if (state == ST_IDLE) begin
        if (!rxd) begin
          state    <= ST_RUN;
          scnt     <= SC_W'(1);
          cell_idx <= '0;
        end
      end else if (scnt == SC_W'(N_SAMP - 1)) begin
        scnt <= '0;
        if (abort || cell_idx == CI_W'(CELLS - 1)) state <= ST_IDLE;
        else cell_idx <= cell_idx + CI_W'(1);
      end else begin
        scnt <= scnt + SC_W'(1);
      end
    end
  end
endmodule

// File: rtl/ovs_bit_decoder.sv
module ovs_bit_decoder #(
  parameter int N_SAMP = 16,
  parameter int DATA_W = 8,
  parameter int THR_W  = 5
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tick,
  input  logic                          rxd,
  input  logic                          strict_mode,
  input  logic [THR_W-1:0]              threshold,
  input  logic                          odd_parity,
  output logic                          bit_valid,
  output logic                          bit_value,
  output logic                          bit_error,
  output logic [N_SAMP-1:0]             bit_samples,
  output logic [$clog2(DATA_W+3)-1:0]   bit_pos,
  output logic                          frame_valid,
  output logic [DATA_W-1:0]             frame_data,
  output logic                          parity_err,
  output logic                          framing_err,
  output logic                          sample_err
);
  localparam int CELLS    = DATA_W + 3;
  localparam int CI_W     = $clog2(CELLS);
  localparam int PAR_CELL = DATA_W + 1;
  localparam int STOP_CELL = DATA_W + 2;

  logic              cell_done, vote_val, vote_err, abort;
  logic [CI_W-1:0]   cidx;
  logic [N_SAMP-1:0] samp_next;
  logic [DATA_W-1:0] data_sh;
  logic              par_bit, err_acc;

  assign abort = cell_done && (cidx == '0) && vote_val;

  ovs_cell_timer #(.N_SAMP(N_SAMP), .CELLS(CELLS)) u_timer (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .abort(abort),
    .cell_done(cell_done), .cell_idx(cidx), .samp_next(samp_next)
  );

  ovs_vote #(.N_SAMP(N_SAMP), .THR_W(THR_W)) u_vote (
    .samples(samp_next), .strict_mode(strict_mode), .threshold(threshold),
    .value(vote_val), .error(vote_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_valid   <= 1'b0;
      bit_value   <= 1'b0;
      bit_error   <= 1'b0;
      bit_samples <= '0;
      bit_pos     <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      parity_err  <= 1'b0;
      framing_err <= 1'b0;
      sample_err  <= 1'b0;
      data_sh     <= '0;
      par_bit     <= 1'b0;
      err_acc     <= 1'b0;
    end else begin
      bit_valid   <= cell_done;
      frame_valid <= 1'b0;
      if (cell_done) begin
        bit_value   <= vote_val;
        bit_error   <= vote_err;
        bit_samples <= samp_next;
        bit_pos     <= cidx;
        err_acc     <= (cidx == '0) ? vote_err : (err_acc | vote_err);
        if (cidx >= CI_W'(1) && cidx <= CI_W'(DATA_W))
          data_sh <= {vote_val, data_sh[DATA_W-1:1]};
        if (cidx == CI_W'(PAR_CELL)) par_bit <= vote_val;
        if (cidx == CI_W'(STOP_CELL)) begin
          frame_valid <= 1'b1;
          frame_data  <= data_sh;
          parity_err  <= ((^data_sh) ^ par_bit) != odd_parity;
          framing_err <= !vote_val;
          sample_err  <= err_acc | vote_err;
        end
      end
    end
  end
endmodule

// File: rtl/ovs_bit_decoder_chk.sv
module ovs_bit_decoder_chk #(
  parameter int N_SAMP = 16,
  parameter int DATA_W = 8
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        strict_mode,
  input logic                        bit_valid,
  input logic                        bit_value,
  input logic                        bit_error,
  input logic [N_SAMP-1:0]           bit_samples,
  input logic [$clog2(DATA_W+3)-1:0] bit_pos,
  input logic                        frame_valid,
  input logic                        framing_err
);
  localparam int LAST = DATA_W + 2;

  a_r3_strobe_single: assert property (@(posedge clk) disable iff (rst)
    bit_valid |=> !bit_valid);

  a_r3_pos_in_range: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (int'(bit_pos) <= LAST));

  a_r2_start_sample_low: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && bit_pos == '0) |-> !bit_samples[N_SAMP-1]);

  a_r4_value_majority: assert property (@(posedge clk) disable iff (rst)
    bit_valid |-> (bit_value == ($countones(bit_samples) >= N_SAMP/2)));

  a_r4_tie_error: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !$past(strict_mode)) |-> (bit_error == ($countones(bit_samples) == N_SAMP/2)));

  a_r9_frame_with_stop: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (bit_valid && int'(bit_pos) == LAST));

  a_r11_framing: assert property (@(posedge clk) disable iff (rst)
    frame_valid |-> (framing_err == !bit_value));
endmodule

bind ovs_bit_decoder ovs_bit_decoder_chk #(.N_SAMP(N_SAMP), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .strict_mode(strict_mode), .bit_valid(bit_valid),
  .bit_value(bit_value), .bit_error(bit_error), .bit_samples(bit_samples),
  .bit_pos(bit_pos), .frame_valid(frame_valid), .framing_err(framing_err)
);

// File: tb/ovs_bit_decoder_test.sv
module ovs_bit_decoder_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 2;

  logic clk = 1'b0, rst = 1'b1, tick = 1'b0, rxd = 1'b1;
  logic strict_mode = 1'b0, odd_parity = 1'b0;
  logic [4:0] threshold = 5'd12;
  logic bit_valid, bit_value, bit_error, frame_valid, parity_err, framing_err, sample_err;
  logic [15:0] bit_samples;
  logic [3:0] bit_pos;
  logic [7:0] frame_data;

  int n_chk = 0, n_bad = 0, n_bits = 0, n_frames = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ovs_bit_decoder uut (
    .clk(clk), .rst(rst), .tick(tick), .rxd(rxd), .strict_mode(strict_mode),
    .threshold(threshold), .odd_parity(odd_parity), .bit_valid(bit_valid),
    .bit_value(bit_value), .bit_error(bit_error), .bit_samples(bit_samples),
    .bit_pos(bit_pos), .frame_valid(frame_valid), .frame_data(frame_data),
    .parity_err(parity_err), .framing_err(framing_err), .sample_err(sample_err)
  );

  always @(posedge clk) if (!rst) begin
    if (bit_valid) n_bits++;
    if (frame_valid) n_frames++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] model(input logic [15:0] s, input logic strict, input logic [4:0] thr);
    int ones, t;
    logic v, e;
    ones = $countones(s);
    t = (thr < 9) ? 9 : ((thr > 16) ? 16 : int'(thr));
    v = (ones >= 8);
    if (!strict) e = (ones == 8);
    else e = !((ones >= t) || ((16 - ones) >= t));
    return {v, e};
  endfunction

  function automatic logic [15:0] make_cell(input logic lvl, input int nflip, input bit keep_first);
    logic [15:0] c, m;
    int placed;
    c = {16{lvl}};
    m = '0;
    placed = 0;
    while (placed < nflip) begin
      int p;
      p = int'($urandom % 16);
      if (!(keep_first && p == 15) && !m[p]) begin
        m[p] = 1'b1;
        placed++;
      end
    end
    return c ^ m;
  endfunction

  task automatic idle_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rxd = 1'b1; tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      repeat (GAP) @(negedge clk);
    end
  endtask

  // drives one cell and checks its result at the falling edge after the 16th tick
  task automatic send_cell(input logic [15:0] s, input int pos, output logic v, output logic e);
    logic [1:0] m;
    for (int i = 15; i >= 0; i--) begin
      @(negedge clk); rxd = s[i]; tick = 1'b1;
      @(negedge clk); tick = 1'b0;
      if (i != 0) repeat (GAP) @(negedge clk);
    end
    m = model(s, strict_mode, threshold);
    v = m[1];
    e = m[0];
    chk(bit_valid == 1'b1, "R3", "bit_valid", int'(bit_valid), 1);
    chk(bit_samples == s, "R3", "bit_samples", int'(bit_samples), int'(s));
    chk(int'(bit_pos) == pos, "R3", "bit_pos", int'(bit_pos), pos);
    chk(bit_value == v, strict_mode ? "R5" : "R4", "bit_value", int'(bit_value), int'(v));
    chk(bit_error == e, strict_mode ? "R5" : "R4", "bit_error", int'(bit_error), int'(e));
  endtask

  task automatic send_frame(input logic [15:0] c [11]);
    logic v, e, serr, pb, fe;
    logic [7:0] d;
    serr = 1'b0;
    d = '0;
    pb = 1'b0;
    fe = 1'b0;
    for (int k = 0; k < 11; k++) begin
      send_cell(c[k], k, v, e);
      serr |= e;
      if (k >= 1 && k <= 8) d[k-1] = v;
      if (k == 9) pb = v;
      if (k == 10) fe = !v;
    end
    chk(frame_valid == 1'b1, "R9", "frame_valid", int'(frame_valid), 1);
    chk(frame_data == d, "R9", "frame_data", int'(frame_data), int'(d));
    chk(parity_err == (((^d) ^ pb) != odd_parity), "R10", "parity_err", int'(parity_err),
        int'(((^d) ^ pb) != odd_parity));
    chk(framing_err == fe, "R11", "framing_err", int'(framing_err), int'(fe));
    chk(sample_err == serr, "R12", "sample_err", int'(sample_err), int'(serr));
    @(negedge clk);
    chk(bit_valid == 1'b0, "R3", "strobe length", int'(bit_valid), 0);
    idle_ticks(3);
  endtask

  task automatic nominal(input logic [7:0] d, input logic pb, input logic sb, output logic [15:0] c [11]);
    c[0] = 16'h0000;
    for (int k = 0; k < 8; k++) c[k+1] = {16{d[k]}};
    c[9] = {16{pb}};
    c[10] = {16{sb}};
  endtask

  initial begin
    logic [15:0] cells [11];
    int b0, f0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(bit_valid == 0 && frame_valid == 0 && bit_samples == 0 && frame_data == 0 &&
        parity_err == 0 && framing_err == 0 && sample_err == 0, "R1", "reset outputs", 0, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(bit_valid == 0 && bit_value == 0 && bit_error == 0 && bit_pos == 0 && frame_valid == 0,
        "R1", "first cycle after reset", int'(bit_valid), 0);

    // R2: high ticks in idle do nothing
    idle_ticks(20);
    chk(n_bits == 0, "R2", "idle bits", n_bits, 0);

    // R4/R9: clean frame, even parity
    nominal(8'hA5, 1'b0, 1'b1, cells);
    send_frame(cells);

    // R4: tie and near-tie in lenient mode
    nominal(8'h3C, 1'b0, 1'b1, cells);
    cells[1] = 16'hFF00;
    cells[2] = 16'h0FF0 ^ 16'h0001;
    send_frame(cells);

    // R5: strict, threshold 12
    strict_mode = 1'b1; threshold = 5'd12;
    nominal(8'h00, 1'b0, 1'b1, cells);
    cells[1] = 16'hFFF0;  // 12 high: accept 1
    cells[2] = 16'hFFE0;  // 11 high: error
    cells[3] = 16'h000F;  // 12 low: accept 0
    cells[4] = 16'h001F;  // 11 low: error
    send_frame(cells);

    // R6: clamp low (3 acts as 9) and high (31 acts as 16)
    threshold = 5'd3;
    nominal(8'h00, 1'b0, 1'b1, cells);
    cells[1] = 16'hFF80;  // 9 high: accept
    cells[2] = 16'hFF00;  // 8 high: error
    send_frame(cells);
    threshold = 5'd31;
    nominal(8'hFF, 1'b0, 1'b1, cells);
    cells[1] = 16'hFFFE;  // 15 high: error under 16
    send_frame(cells);

    // R10/R11: odd parity mismatch and low stop
    strict_mode = 1'b0; odd_parity = 1'b1;
    nominal(8'h01, 1'b1, 1'b0, cells);
    send_frame(cells);

    // R8: false start then a good frame
    b0 = n_bits; f0 = n_frames;
    begin
      logic v, e;
      send_cell(16'h7FFF, 0, v, e);
    end
    idle_ticks(40);
    chk(n_bits == b0 + 1, "R8", "bits after false start", n_bits, b0 + 1);
    chk(n_frames == f0, "R8", "frames after false start", n_frames, f0);
    nominal(8'h5A, 1'b1, 1'b1, cells);
    send_frame(cells);

    // random frames
    for (int f = 0; f < 40; f++) begin
      logic [7:0] d;
      logic pb, sb, strict;
      int nf;
      strict = $urandom % 2;
      strict_mode = strict;
      threshold = 5'($urandom % 32);
      odd_parity = $urandom % 2;
      d = 8'($urandom);
      pb = ((^d) ^ odd_parity) ^ (($urandom % 5) == 0);
      sb = ($urandom % 7) != 0;
      nominal(d, pb, sb, cells);
      cells[0] = make_cell(1'b0, int'($urandom % 6), 1'b1);
      for (int k = 1; k < 11; k++) begin
        logic lvl;
        lvl = cells[k][0];
        if (strict) nf = int'($urandom % 6);
        else nf = (($urandom % 10) == 0) ? 8 : int'($urandom % 8);
        cells[k] = make_cell(lvl, nf, 1'b0);
        if (!strict && nf < 8)  // R7
          chk((($countones(cells[k]) >= 8) == lvl) && ($countones(cells[k]) != 8), "R7",
              "noise stays minority", $countones(cells[k]), int'(lvl));
      end
      send_frame(cells);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule